// File: doc/BRIEF.md
# Carrier-Gap Command Decoder and Load-Modulation Replier

This block sits on the tag side of a low-frequency inductive link. The reader sends commands by briefly switching off its carrier field. A thresholded copy of the field arrives on `field_in`, and a one-cycle strobe arrives on `carrier_tick` once per carrier period. The block measures the number of carrier periods between successive rising edges of the field. It turns each interval into a data bit, or drops the interval when it is out of range. When the field stays quiet long enough, the block closes the frame and hands the collected bits to the command logic.

The command logic answers by loading a response on `tx_frame` and `tx_len` and pulsing `tx_start`. The block waits until a programmable number of carrier periods have passed since the last reader edge. It then drives `load_out` to switch the antenna load. The reply is a start bit followed by the response bits, each Manchester-coded over a fixed number of carrier periods. Field edges seen while the reply is on the air are not decoded.

Top module: `lf_gap_link`

## Requirements
- R1: While reset is asserted, `load_out` and `rx_valid` are 0 and `rx_len` and `rx_frame` are all zeros.
- R2: A rise-to-rise interval of 24 to 40 carrier ticks, inclusive, is stored as a 1 bit.
- R3: A rise-to-rise interval of 15 to 23 carrier ticks, inclusive, is stored as a 0 bit.
- R4: An interval shorter than 15 ticks or longer than 40 ticks stores no bit, and the frame in progress continues.
- R5: When 41 ticks pass after the last accepted rising edge, a frame holding at least one bit is handed off. `rx_valid` is high for one cycle, and `rx_frame` and `rx_len` hold the frame until the next hand-off. A frame with no bits is discarded silently.
- R6: The first received bit lands in `rx_frame[FRAME_BITS-1]` and each later bit one position lower, so every byte is MSB first. Unfilled positions read 0.
- R7: Bits beyond `FRAME_BITS` are dropped, while `rx_len` keeps counting every decoded bit, saturating at 2**LEN_W-1.
- R8: After `tx_start`, the first loaded half of the reply begins once `fdt-8` ticks have elapsed since the last accepted rising edge. If `fdt` is below 8, the target is 0 ticks. If the target has already passed, the reply begins at once.
- R9: The reply is a start bit of value 1, followed by `min(tx_len, FRAME_BITS)` bits taken from `tx_frame[FRAME_BITS-1]` downward.
- R10: Each reply bit lasts 31 ticks. A 1 drives `load_out` high for 15 ticks and then low for 16, and a 0 does the opposite. `load_out` stays low outside a reply.
- R11: Rising edges of `field_in` during a reply produce no bits and no hand-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_tick | input | 1 | One-cycle strobe per carrier period |
| field_in | input | 1 | Thresholded reader field, high when the carrier is present |
| tx_frame | input | FRAME_BITS (64) | Response bits, first bit in the top position |
| tx_len | input | LEN_W (8) | Number of response bits |
| tx_start | input | 1 | Request to send the response |
| fdt | input | CNT_W (10) | Reply delay in carrier ticks, measured from the last reader edge |
| rx_frame | output | FRAME_BITS (64) | Last received frame, first bit in the top position |
| rx_len | output | LEN_W (8) | Bit count of the last received frame |
| rx_valid | output | 1 | One-cycle strobe when a frame is handed off |
| load_out | output | 1 | Antenna load switch, high means loaded |

## Verification
The bench builds the block with its default parameters: a 64-bit frame, an 8-bit length, a 10-bit tick counter, interval limits of 15, 24 and 40, and a 15/31-tick Manchester bit. A sweep of every interval from 10 to 45 ticks reaches both edges of each decode window, as well as the case where the end-of-frame limit fires in the middle of an interval. A 70-bit frame reaches the overflow rule. Replies built with `fdt` values of 208, 60 and 20, with lengths of 0, 5, 16 and 70, cover a delayed start, an immediate start and the length cap. Field pulses injected during replies exercise the receive blanking.

// File: rtl/lf_gap_pkg.sv
package lf_gap_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic valid;
      logic value;
   } sym_t;

endpackage

// File: rtl/lf_gap_timer.sv
module lf_gap_timer
   import lf_gap_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int T0_MIN  = 15,
   parameter int T1_MIN  = 24,
   parameter int EOF_LIM = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             carrier_tick,
   input  logic             field_in,
   input  logic             rx_block,
   output sym_t             sym,
   output logic             eof_pulse,
   output logic [CNT_W-1:0] since_edge
);

   localparam logic [CNT_W-1:0] T0_C    = CNT_W'(T0_MIN);
   localparam logic [CNT_W-1:0] T1_C    = CNT_W'(T1_MIN);
   localparam logic [CNT_W-1:0] EOF_C   = CNT_W'(EOF_LIM);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (!(T0_MIN > 0 && T0_MIN < T1_MIN && T1_MIN <= EOF_LIM)) begin : g_bad_windows
      $error("lf_gap_timer: interval windows out of order");
   end
   if (EOF_LIM + 1 >= (2 ** CNT_W)) begin : g_bad_width
      $error("lf_gap_timer: CNT_W too small for EOF_LIM");
   end

   logic             field_q;
   logic             take_edge;
   logic [CNT_W-1:0] cnt_q;

   assign take_edge = field_in && !field_q && !rx_block;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q <= 1'b0;
         cnt_q   <= CNT_MAX;
      end else begin
         field_q <= field_in;
         if (take_edge) begin
            cnt_q <= '0;
         end else if (carrier_tick && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
         end
      end
   end

   always_comb begin
      sym.valid  = take_edge && (cnt_q >= T0_C) && (cnt_q <= EOF_C);
      sym.value  = (cnt_q >= T1_C);
      eof_pulse  = carrier_tick && (cnt_q == EOF_C) && !take_edge;
      since_edge = cnt_q;
   end

endmodule

// File: rtl/lf_gap_rxbuf.sv
module lf_gap_rxbuf
   import lf_gap_pkg::*;
#(
   parameter int FRAME_BITS = 64,
   parameter int LEN_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  sym_t                  sym,
   input  logic                  eof_pulse,
   output logic [FRAME_BITS-1:0] rx_frame,
   output logic [LEN_W-1:0]      rx_len,
   output logic                  rx_valid
);

   localparam logic [LEN_W-1:0] LEN_MAX = '1;
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   if (FRAME_BITS < 1 || FRAME_BITS + 1 > (2 ** LEN_W) - 1) begin : g_bad_len
      $error("lf_gap_rxbuf: LEN_W too small for FRAME_BITS");
   end

   logic [FRAME_BITS-1:0] buf_q;
   logic [FRAME_BITS-1:0] wr_en;
   logic [LEN_W-1:0]      pos_q;

   for (genvar b = 0; b < FRAME_BITS; b++) begin : g_wr
      assign wr_en[b] = sym.valid && (pos_q == LEN_W'(FRAME_BITS - 1 - b));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q    <= '0;
         pos_q    <= '0;
         rx_frame <= '0;
         rx_len   <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (eof_pulse) begin
            if (pos_q != '0) begin
               rx_frame <= buf_q;
               rx_len   <= pos_q;
               rx_valid <= 1'b1;
            end
            buf_q <= '0;
            pos_q <= '0;
         end else if (sym.valid) begin
            for (int b = 0; b < FRAME_BITS; b++) begin
               if (wr_en[b]) buf_q[b] <= sym.value;
            end
            if (pos_q != LEN_MAX) pos_q <= pos_q + LEN_ONE;
         end
      end
   end

   assert_handoff_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (rx_len != '0));

   assert_handoff_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

// File: rtl/lf_gap_mtx.sv
module lf_gap_mtx
   import lf_gap_pkg::*;
#(
   parameter int FRAME_BITS = 64,
   parameter int LEN_W      = 8,
   parameter int CNT_W      = 10,
   parameter int GAP_ADJ    = 8,
   parameter int HALF       = 15,
   parameter int BIT_T      = 31
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  carrier_tick,
   input  logic                  tx_start,
   input  logic [FRAME_BITS-1:0] tx_frame,
   input  logic [LEN_W-1:0]      tx_len,
   input  logic [CNT_W-1:0]      fdt,
   input  logic [CNT_W-1:0]      since_edge,
   output logic                  load_out,
   output logic                  busy
);

   localparam int PH_W = $clog2(BIT_T);
   localparam logic [PH_W-1:0]  PH_MID  = PH_W'(HALF - 1);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(BIT_T - 1);
   localparam logic [PH_W-1:0]  PH_ONE  = PH_W'(1);
   localparam logic [LEN_W-1:0] FB_C    = LEN_W'(FRAME_BITS);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [CNT_W-1:0] GAP_C   = CNT_W'(GAP_ADJ);

   if (!(HALF > 0 && HALF < BIT_T && BIT_T > 1)) begin : g_bad_bit
      $error("lf_gap_mtx: Manchester half must lie inside the bit");
   end
   if (GAP_ADJ >= (2 ** CNT_W)) begin : g_bad_gap
      $error("lf_gap_mtx: GAP_ADJ does not fit CNT_W");
   end

   tx_state_e             state_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic [LEN_W-1:0]      nb_q;
   logic [LEN_W-1:0]      idx_q;
   logic [PH_W-1:0]       ph_q;
   logic                  bit_q;
   logic                  load_q;
   logic [CNT_W-1:0]      trig;
   logic [LEN_W-1:0]      len_cap;
   logic                  go;

   always_comb begin
      trig    = (fdt > GAP_C) ? (fdt - GAP_C) : '0;
      len_cap = (tx_len > FB_C) ? FB_C : tx_len;
      go      = (state_q == TX_WAIT) && (since_edge >= trig);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         sh_q    <= '0;
         nb_q    <= '0;
         idx_q   <= '0;
         ph_q    <= '0;
         bit_q   <= 1'b0;
         load_q  <= 1'b0;
      end else begin
         case (state_q)
            TX_IDLE: begin
               if (tx_start) begin
                  sh_q    <= tx_frame;
                  nb_q    <= len_cap + LEN_ONE;
                  state_q <= TX_WAIT;
               end
            end
            TX_WAIT: begin
               if (go) begin
                  state_q <= TX_SEND;
                  idx_q   <= '0;
                  ph_q    <= '0;
                  bit_q   <= 1'b1;
                  load_q  <= 1'b1;
               end
            end
            TX_SEND: begin
               if (carrier_tick) begin
                  if (ph_q == PH_LAST) begin
                     ph_q <= '0;
                     if (idx_q + LEN_ONE == nb_q) begin
                        state_q <= TX_IDLE;
                        load_q  <= 1'b0;
                     end else begin
                        idx_q  <= idx_q + LEN_ONE;
                        bit_q  <= sh_q[FRAME_BITS-1];
                        load_q <= sh_q[FRAME_BITS-1];
                        sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b0};
                     end
                  end else begin
                     ph_q <= ph_q + PH_ONE;
                     if (ph_q == PH_MID) load_q <= ~bit_q;
                  end
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign load_out = load_q;
   assign busy     = (state_q == TX_SEND);

   assert_load_steps_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(load_q) |-> ($past(carrier_tick) || ($past(state_q) == TX_WAIT)));

   assert_load_off_outside_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != TX_SEND) |-> !load_q);

endmodule

// File: rtl/lf_gap_link.sv
module lf_gap_link
   import lf_gap_pkg::*;
#(
   parameter int FRAME_BITS = 64,
   parameter int LEN_W      = 8,
   parameter int CNT_W      = 10,
   parameter int T0_MIN     = 15,
   parameter int T1_MIN     = 24,
   parameter int EOF_LIM    = 40,
   parameter int GAP_ADJ    = 8,
   parameter int HALF       = 15,
   parameter int BIT_T      = 31
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  carrier_tick,
   input  logic                  field_in,
   input  logic [FRAME_BITS-1:0] tx_frame,
   input  logic [LEN_W-1:0]      tx_len,
   input  logic                  tx_start,
   input  logic [CNT_W-1:0]      fdt,
   output logic [FRAME_BITS-1:0] rx_frame,
   output logic [LEN_W-1:0]      rx_len,
   output logic                  rx_valid,
   output logic                  load_out
);

   sym_t             sym;
   logic             eof_pulse;
   logic [CNT_W-1:0] since_edge;
   logic             tx_busy;

   lf_gap_timer #(
      .CNT_W  (CNT_W),
      .T0_MIN (T0_MIN),
      .T1_MIN (T1_MIN),
      .EOF_LIM(EOF_LIM)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .carrier_tick(carrier_tick),
      .field_in    (field_in),
      .rx_block    (tx_busy),
      .sym         (sym),
      .eof_pulse   (eof_pulse),
      .since_edge  (since_edge)
   );

   lf_gap_rxbuf #(
      .FRAME_BITS(FRAME_BITS),
      .LEN_W     (LEN_W)
   ) u_rxbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym      (sym),
      .eof_pulse(eof_pulse),
      .rx_frame (rx_frame),
      .rx_len   (rx_len),
      .rx_valid (rx_valid)
   );

   lf_gap_mtx #(
      .FRAME_BITS(FRAME_BITS),
      .LEN_W     (LEN_W),
      .CNT_W     (CNT_W),
      .GAP_ADJ   (GAP_ADJ),
      .HALF      (HALF),
      .BIT_T     (BIT_T)
   ) u_mtx (
      .clk         (clk),
      .rst_n       (rst_n),
      .carrier_tick(carrier_tick),
      .tx_start    (tx_start),
      .tx_frame    (tx_frame),
      .tx_len      (tx_len),
      .fdt         (fdt),
      .since_edge  (since_edge),
      .load_out    (load_out),
      .busy        (tx_busy)
   );

   assert_rx_quiet_in_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !sym.valid);

endmodule

// File: tb/sim_lf_gap_link.sv
module sim_lf_gap_link;

   localparam int FB = 64;
   localparam int LW = 8;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          carrier_tick = 1'b0;
   logic          field_in = 1'b1;
   logic [FB-1:0] tx_frame = '0;
   logic [LW-1:0] tx_len = '0;
   logic          tx_start = 1'b0;
   logic [CW-1:0] fdt = 10'd208;
   logic [FB-1:0] rx_frame;
   logic [LW-1:0] rx_len;
   logic          rx_valid;
   logic          load_out;

   lf_gap_link u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .carrier_tick(carrier_tick),
      .field_in    (field_in),
      .tx_frame    (tx_frame),
      .tx_len      (tx_len),
      .tx_start    (tx_start),
      .fdt         (fdt),
      .rx_frame    (rx_frame),
      .rx_len      (rx_len),
      .rx_valid    (rx_valid),
      .load_out    (load_out)
   );

   always #10 clk = ~clk;

   int total = 0;
   int bad = 0;
   int tk = 0;
   int got_cnt = 0;
   logic [FB-1:0] got_frame = '0;
   int got_len = 0;
   bit mon_on = 0;
   int mon_trig = 0;
   int mon_nb = 0;
   logic [FB-1:0] mon_frame = '0;
   int mon_bad_k = -1;
   int mon_bad_act = 0;
   int mon_bad_exp = 0;
   int mon_first = -1;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_level(input int k);
      int b;
      logic v;
      b = k / 31;
      if (b >= mon_nb) return 1'b0;
      v = (b == 0) ? 1'b1 : mon_frame[FB - b];
      return ((k % 31) < 15) ? v : ~v;
   endfunction

   task automatic observe();
      logic e;
      if (mon_on) begin
         e = (tk < mon_trig) ? 1'b0 : exp_level(tk - mon_trig);
         if (load_out && mon_first < 0) mon_first = tk;
         if (load_out !== e && mon_bad_k < 0) begin
            mon_bad_k = tk;
            mon_bad_act = int'(load_out);
            mon_bad_exp = int'(e);
         end
      end
   endtask

   task automatic clk1(input bit t);
      @(negedge clk);
      if (rx_valid) begin
         got_cnt++;
         got_frame = rx_frame;
         got_len = int'(rx_len);
      end
      carrier_tick = t;
      if (t) begin
         observe();
         tk++;
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         clk1(1'b1); clk1(1'b0); clk1(1'b0); clk1(1'b0);
      end
   endtask

   task automatic noisy_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         clk1(1'b1); clk1(1'b0); clk1(1'b0); clk1(1'b0);
         if (i % 23 == 22) begin
            field_in = 1'b0; clk1(1'b0);
            field_in = 1'b1; clk1(1'b0);
         end
      end
   endtask

   task automatic rise_edge();
      field_in = 1'b1;
      clk1(1'b0);
      tk = 0;
   endtask

   task automatic start_frame();
      field_in = 1'b0;
      ticks(5);
      rise_edge();
   endtask

   task automatic send_ivl(input int n);
      ticks(n - 5);
      field_in = 1'b0;
      ticks(5);
      rise_edge();
   endtask

   task automatic send_pattern(input logic [127:0] bits, input int nb);
      start_frame();
      for (int i = 0; i < nb; i++) begin
         if (bits[i]) send_ivl(24 + (i % 17));
         else send_ivl(15 + (i % 9));
      end
   endtask

   task automatic do_reply(input int fdt_v, input logic [FB-1:0] frm, input int len, input bit noise);
      int gc, trig, nb, stop;
      fdt = CW'(fdt_v);
      start_frame();
      send_ivl(30);
      send_ivl(18);
      ticks(45);
      gc = got_cnt;
      tx_frame = frm;
      tx_len = LW'(len);
      trig = (fdt_v > 8) ? fdt_v - 8 : 0;
      if (trig < tk) trig = tk;
      nb = ((len > FB) ? FB : len) + 1;
      mon_trig = trig; mon_nb = nb; mon_frame = frm;
      mon_bad_k = -1; mon_first = -1; mon_on = 1;
      tx_start = 1'b1; clk1(1'b0);
      tx_start = 1'b0; clk1(1'b0);
      stop = trig + nb * 31 + 5;
      ticks(trig - tk);
      if (noise) noisy_ticks(stop - tk);
      else ticks(stop - tk);
      mon_on = 0;
      check(mon_first == trig, "R8 reply start tick", 64'(mon_first), 64'(trig));
      check(mon_bad_k < 0, "R9 R10 reply waveform level", 64'(mon_bad_act), 64'(mon_bad_exp));
      ticks(50);
      check(got_cnt == gc, "R11 no hand-off from edges during reply", 64'(got_cnt), 64'(gc));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [127:0] pat;
      logic [FB-1:0] ef;
      int gc0, el;

      rst_n = 1'b0;
      clk1(1'b0); clk1(1'b0); clk1(1'b0);
      check(load_out == 1'b0 && rx_valid == 1'b0 && rx_len == '0 && rx_frame == '0,
            "R1 reset outputs", {rx_frame[63:3], load_out, rx_valid, |rx_len}, 64'd0);
      rst_n = 1'b1;
      ticks(60);

      // R2 R3 R4: sweep every interval around the windows
      for (int n = 10; n <= 45; n++) begin
         start_frame();
         send_ivl(n);
         send_ivl(17);
         gc0 = got_cnt;
         ticks(45);
         if (n >= 15 && n <= 40) begin
            el = 2;
            ef = {(n >= 24), {(FB-1){1'b0}}};
         end else begin
            el = 1;
            ef = '0;
         end
         check(got_cnt == gc0 + 1 && got_len == el && got_frame == ef,
               (n >= 24 && n <= 40) ? "R2 one window" : ((n >= 15 && n <= 40) ? "R3 zero window" : "R4 rejected interval"),
               got_frame ^ 64'(got_len), ef ^ 64'(el));
      end

      // R5: a frame with only rejected intervals is never handed off
      gc0 = got_cnt;
      start_frame();
      send_ivl(12);
      ticks(45);
      check(got_cnt == gc0, "R5 empty frame discarded", 64'(got_cnt), 64'(gc0));

      // R6: MSB-first packing with mixed intervals
      pat = 128'h0;
      pat[19:0] = 20'hB3A6D;
      send_pattern(pat, 20);
      gc0 = got_cnt;
      ticks(45);
      ef = '0;
      for (int i = 0; i < 20; i++) ef[FB-1-i] = pat[i];
      check(got_cnt == gc0 + 1 && got_len == 20 && got_frame == ef, "R6 20-bit frame", got_frame, ef);

      pat = 128'h0;
      pat[63:0] = 64'hC0FF_EE12_9A5D_3B71;
      send_pattern(pat, 64);
      gc0 = got_cnt;
      ticks(45);
      for (int i = 0; i < 64; i++) ef[FB-1-i] = pat[i];
      check(got_cnt == gc0 + 1 && got_len == 64 && got_frame == ef, "R6 full frame", got_frame, ef);
      check(rx_frame == ef, "R5 frame held after hand-off", rx_frame, ef);

      // R7: overflow past the buffer
      pat = 128'h0;
      pat[69:0] = 70'h2A_5F0F_3C96_E1D4_7B28;
      send_pattern(pat, 70);
      gc0 = got_cnt;
      ticks(45);
      for (int i = 0; i < 64; i++) ef[FB-1-i] = pat[i];
      check(got_cnt == gc0 + 1 && got_len == 70, "R7 length keeps counting", 64'(got_len), 64'd70);
      check(got_frame == ef, "R7 extra bits dropped", got_frame, ef);

      // R8 R9 R10 R11: replies
      do_reply(208, 64'hA5C3_0F96_1234_5678, 16, 1'b1);
      do_reply(60, 64'h6800_0000_0000_0000, 5, 1'b1);
      do_reply(208, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0);
      do_reply(20, 64'h1E2D_3C4B_5A69_7887, 70, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule